// File: doc/BRIEF.md
# Output Voltage Droop Reference Generator

This block produces the digital output-voltage reference used when several supplies share a load current. It starts from a programmed nominal setpoint word and lowers it in proportion to the output current: the current is averaged over a block of samples, the average is multiplied by a programmable droop resistance, and the scaled product is taken off the setpoint. When the product is larger than the setpoint, the result stops at zero.

The current arrives as a stream of samples, each marked by a valid strobe. A 2-bit speed code sets how many samples make up one averaging window. Each code doubles the window, so the four codes map to 82, 164, 328 and 656 us at the nominal sample rate. The window length is a power of two, so the averager divides by shifting. At the end of every window the reference output is loaded once and a one-cycle update pulse is raised. Between updates the reference holds its value. The droop resistance and the speed code are set independently of each other.

Top module: `droop_ref_gen`

## Requirements
- R1: During and right after reset, `vref_o` is 0 and `vref_upd_o` is 0.
- R2: A window holds 4·2^code accepted samples (code 0..3 gives 4, 8, 16, 32). `vref_upd_o` is high in the cycle right after the clock edge that accepts the last sample of the window, and at no earlier point.
- R3: The window average is the sum of its samples shifted right by log2 of the window length, which rounds down.
- R4: At an update, `vref_o` = `setpoint_i` − ((average × `droop_res_i`) >> 4). The setpoint and resistance used are the ones present in the cycle that accepts the last sample.
- R5: With `droop_res_i` = 0, an update sets `vref_o` equal to `setpoint_i`, whatever the current.
- R6: If the droop term is equal to or larger than the setpoint, `vref_o` becomes 0 and does not wrap.
- R7: `vref_o` changes only in a cycle where `vref_upd_o` is high. `vref_upd_o` never stays high for two cycles in a row.
- R8: The accumulator clears at each window boundary, so a window's result depends only on the samples of that window.
- R9: The speed code is taken when the first sample of a window is accepted. A change to the code after that point takes effect from the next window.
- R10: Cycles with `cur_vld_i` low do not count toward the window and do not add to the sum, whatever value `cur_smp_i` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setpoint_i | input | 16 | Nominal output-voltage setpoint word |
| droop_res_i | input | 8 | Droop resistance, 1 mOhm per LSB |
| avg_speed_i | input | 2 | Averaging-window code, 0 fastest to 3 slowest |
| cur_vld_i | input | 1 | Current sample valid strobe |
| cur_smp_i | input | 12 | Output current sample |
| vref_o | output | 16 | Drooped output-voltage reference |
| vref_upd_o | output | 1 | One-cycle pulse when `vref_o` is loaded |

## Verification
Constant, ramping and full-scale alternating current streams are run through every window length. A wrong shift, sample count or sum shows up as a different reference, and an off-by-one window count shows up as a shifted update pulse. One stream has a sum that does not divide evenly, which tells a floor average apart from a rounded one. Saturation is tried both with the droop term equal to the setpoint and with it far above, which separates a clamp from a wrap. Gaps filled with full-scale garbage, a speed change in the middle of a window and a zero resistance each check that an input which should have no effect leaves the reference as predicted.

// File: rtl/droop_pkg.sv
package droop_pkg;

  // Averaging speed codes; each step doubles the window length.
  typedef enum logic [1:0] {
    SPD_X1 = 2'd0,
    SPD_X2 = 2'd1,
    SPD_X4 = 2'd2,
    SPD_X8 = 2'd3
  } speed_e;

  // log2 of the number of samples in a window for a given speed code.
  function automatic int unsigned win_shift(input int unsigned base_log2,
                                            input logic [1:0] code);
    return base_log2 + 32'(code);
  endfunction

endpackage

// File: rtl/droop_window_ctrl.sv
module droop_window_ctrl
  import droop_pkg::*;
#(
  parameter int unsigned BASE_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       smp_vld,
  input  logic [1:0] spd_sel,
  output logic       win_last,
  output logic [1:0] eff_code
);

  localparam int unsigned CNT_W = BASE_LOG2 + 4;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_max;
  logic [1:0]       held_code;
  logic             win_open;

  // The code is live until the first sample of a window is taken.
  assign win_open = (cnt != '0);

  always_comb begin
    eff_code = win_open ? held_code : spd_sel;
    cnt_max  = CNT_W'((64'd1 << win_shift(BASE_LOG2, eff_code)) - 64'd1);
    win_last = smp_vld && (cnt == cnt_max);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      held_code <= SPD_X1;
    end else if (smp_vld) begin
      if (!win_open) held_code <= spd_sel;
      cnt <= win_last ? '0 : cnt + 1'b1;
    end
  end

  // R2: the sample counter never passes the end of its window
  assert_cnt_in_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cnt_max);

  // R9: once a window is open its length does not move until it closes
  assert_len_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((win_open || smp_vld) && !win_last) |=> (eff_code == $past(eff_code)));

  // R10: an idle cycle leaves the window position untouched
  assert_idle_no_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> (cnt == $past(cnt)));

endmodule

// File: rtl/droop_averager.sv
module droop_averager
  import droop_pkg::*;
#(
  parameter int unsigned CUR_W     = 12,
  parameter int unsigned BASE_LOG2 = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_vld,
  input  logic [CUR_W-1:0] smp_i,
  input  logic             win_last,
  input  logic [1:0]       eff_code,
  output logic [CUR_W-1:0] avg_o
);

  localparam int unsigned ACC_W = CUR_W + BASE_LOG2 + 3;

  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] sum_now;

  // Power-of-two window: the divide is a plain right shift (floor).
  function automatic logic [CUR_W-1:0] window_avg(input logic [ACC_W-1:0] sum,
                                                  input logic [1:0] code);
    return CUR_W'(sum >> win_shift(BASE_LOG2, code));
  endfunction

  assign sum_now = acc + ACC_W'(smp_i);
  assign avg_o   = window_avg(sum_now, eff_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
    end else if (smp_vld) begin
      acc <= win_last ? '0 : sum_now;
    end
  end

  // R8: a new window starts from an empty accumulator
  assert_acc_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
    win_last |=> (acc == '0));

  // R10: samples without a strobe add nothing
  assert_idle_no_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_vld |=> $stable(acc));

endmodule

// File: rtl/droop_ref_calc.sv
module droop_ref_calc #(
  parameter int unsigned SP_W       = 16,
  parameter int unsigned CUR_W      = 12,
  parameter int unsigned RES_W      = 8,
  parameter int unsigned PROD_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_last,
  input  logic [CUR_W-1:0] avg_i,
  input  logic [SP_W-1:0]  setpoint_i,
  input  logic [RES_W-1:0] res_i,
  output logic [SP_W-1:0]  ref_o,
  output logic             upd_o
);

  localparam int unsigned PROD_W = CUR_W + RES_W;
  localparam int unsigned CMP_W  = (PROD_W > SP_W) ? PROD_W : SP_W;

  // Setpoint minus scaled droop, saturating at zero.
  function automatic logic [SP_W-1:0] droop_ref(input logic [SP_W-1:0]  sp,
                                                input logic [CUR_W-1:0] avg,
                                                input logic [RES_W-1:0] res);
    logic [PROD_W-1:0] prod;
    logic [CMP_W-1:0]  drop;
    logic [CMP_W-1:0]  spx;
    prod = PROD_W'(avg) * PROD_W'(res);
    drop = CMP_W'(prod >> PROD_SHIFT);
    spx  = CMP_W'(sp);
    if (drop >= spx) return '0;
    return SP_W'(spx - drop);
  endfunction

  logic [SP_W-1:0] ref_next;
  assign ref_next = droop_ref(setpoint_i, avg_i, res_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_o <= '0;
      upd_o <= 1'b0;
    end else begin
      upd_o <= win_last;
      if (win_last) ref_o <= ref_next;
    end
  end

  // R6: an update never yields more than the setpoint (no wrap-around)
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |-> (ref_o <= $past(setpoint_i)));

  // R5: zero resistance passes the setpoint through
  assert_zero_res_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_o && ($past(res_i) == '0)) |-> (ref_o == $past(setpoint_i)));

  // R7: reference holds between updates
  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_o |-> $stable(ref_o));

  // R7: the update strobe is a single-cycle pulse
  assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    upd_o |=> !upd_o);

endmodule

// File: rtl/droop_ref_gen.sv
module droop_ref_gen #(
  parameter int unsigned SP_W       = 16,
  parameter int unsigned CUR_W      = 12,
  parameter int unsigned RES_W      = 8,
  parameter int unsigned BASE_LOG2  = 2,
  parameter int unsigned PROD_SHIFT = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SP_W-1:0]  setpoint_i,
  input  logic [RES_W-1:0] droop_res_i,
  input  logic [1:0]       avg_speed_i,
  input  logic             cur_vld_i,
  input  logic [CUR_W-1:0] cur_smp_i,
  output logic [SP_W-1:0]  vref_o,
  output logic             vref_upd_o
);

  // Internal events brought out by name.
  logic             win_last;
  logic [1:0]       eff_code;
  logic [CUR_W-1:0] win_avg;

  droop_window_ctrl #(
    .BASE_LOG2 (BASE_LOG2)
  ) u_win (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (cur_vld_i),
    .spd_sel  (avg_speed_i),
    .win_last (win_last),
    .eff_code (eff_code)
  );

  droop_averager #(
    .CUR_W     (CUR_W),
    .BASE_LOG2 (BASE_LOG2)
  ) u_avg (
    .clk      (clk),
    .rst_n    (rst_n),
    .smp_vld  (cur_vld_i),
    .smp_i    (cur_smp_i),
    .win_last (win_last),
    .eff_code (eff_code),
    .avg_o    (win_avg)
  );

  droop_ref_calc #(
    .SP_W       (SP_W),
    .CUR_W      (CUR_W),
    .RES_W      (RES_W),
    .PROD_SHIFT (PROD_SHIFT)
  ) u_ref (
    .clk        (clk),
    .rst_n      (rst_n),
    .win_last   (win_last),
    .avg_i      (win_avg),
    .setpoint_i (setpoint_i),
    .res_i      (droop_res_i),
    .ref_o      (vref_o),
    .upd_o      (vref_upd_o)
  );

  // R2: an update follows exactly the cycle that closed a window
  assert_upd_after_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
    vref_upd_o |-> $past(cur_vld_i));

endmodule

// File: tb/droop_ref_gen_tb_top.sv
module droop_ref_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] setpoint_i = '0;
  logic [7:0]  droop_res_i = '0;
  logic [1:0]  avg_speed_i = '0;
  logic        cur_vld_i = 1'b0;
  logic [11:0] cur_smp_i = '0;
  logic [15:0] vref_o;
  logic        vref_upd_o;

  int checks = 0;
  int failures = 0;
  int upd_cnt = 0;
  bit finished = 0;

  int exp_q[$];
  string tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  droop_ref_gen dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .setpoint_i  (setpoint_i),
    .droop_res_i (droop_res_i),
    .avg_speed_i (avg_speed_i),
    .cur_vld_i   (cur_vld_i),
    .cur_smp_i   (cur_smp_i),
    .vref_o      (vref_o),
    .vref_upd_o  (vref_upd_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample generator for the stimulus patterns.
  function automatic int smp_val(input int kind, input int seed, input int i);
    case (kind)
      0: return seed & 12'hFFF;                    // constant
      1: return (seed + 37 * i) & 12'hFFF;         // ramp
      2: return (i % 2 == 0) ? 12'hFFF : 0;        // full-scale alternating
      default: return (i == 0) ? 1 : 2;            // uneven sum
    endcase
  endfunction

  // Reference model written from the requirements.
  function automatic int model_ref(input int sp, input int res, input int sum, input int sel);
    int avg;
    int drop;
    avg  = sum >> (2 + sel);
    drop = (avg * res) >> 4;
    if (drop >= sp) return 0;
    return sp - drop;
  endfunction

  // Driver: plays one window and pushes its expected reference.
  task automatic run_window(input int sel, input int sp, input int res,
                            input int kind, input int seed, input int gap,
                            input int mid_sel, input string tag);
    int n;
    int sum;
    int start_upd;
    n = 4 << sel;
    sum = 0;
    for (int i = 0; i < n; i++) sum += smp_val(kind, seed, i);
    exp_q.push_back(model_ref(sp, res, sum, sel));
    tag_q.push_back(tag);
    @(negedge clk);
    setpoint_i  = 16'(sp);
    droop_res_i = 8'(res);
    avg_speed_i = 2'(sel);
    start_upd = upd_cnt;
    for (int i = 0; i < n; i++) begin
      if (i == n - 1) begin
        #1;
        // R2: nothing published before the closing sample
        check(upd_cnt == start_upd, {"R2 early update ", tag}, upd_cnt - start_upd, 0);
      end
      cur_vld_i = 1'b1;
      cur_smp_i = 12'(smp_val(kind, seed, i));
      @(negedge clk);
      cur_vld_i = 1'b0;
      if (i == 0 && mid_sel >= 0) avg_speed_i = 2'(mid_sel);
      // R10: idle cycles carry garbage that must be ignored
      for (int g = 0; g < gap; g++) begin
        cur_smp_i = 12'hFFF;
        @(negedge clk);
      end
    end
    #1;
    // R2: the update lands one cycle after the closing sample
    check(upd_cnt == start_upd + 1, {"R2 update timing ", tag}, upd_cnt - start_upd, 1);
  endtask

  // Monitor: compares each published reference with the scoreboard.
  logic [15:0] prev_ref = '0;
  bit prev_upd = 0;
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (vref_upd_o) begin
        upd_cnt++;
        // R7: single-cycle pulse
        check(!prev_upd, "R7 pulse width", 1, 0);
        if (exp_q.size() == 0) begin
          check(0, "R2 unexpected update", int'(vref_o), -1);
        end else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(int'(vref_o) == e, t, int'(vref_o), e);
        end
      end else begin
        // R7: hold between updates
        if (vref_o != prev_ref) check(0, "R7 reference moved without update", int'(vref_o), int'(prev_ref));
      end
      prev_ref = vref_o;
      prev_upd = vref_upd_o;
    end
  end

  initial begin
    fork
      begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
          check(0, "watchdog expired", 0, 1);
          finished = 1;
          $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
          $finish;
        end
      end
    join_none

    repeat (3) @(negedge clk);
    // R1: reset state
    check(vref_o == 16'd0, "R1 reset vref", int'(vref_o), 0);
    check(vref_upd_o == 1'b0, "R1 reset upd", int'(vref_upd_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vref_o == 16'd0 && vref_upd_o == 1'b0, "R1 after reset", int'(vref_o), 0);

    // R4: constant current, each window length (R2)
    run_window(0, 30000, 100, 0, 800, 0, -1, "R4 const sel0");
    run_window(1, 30000, 100, 0, 800, 0, -1, "R4 const sel1");
    run_window(2, 20000, 37, 1, 100, 0, -1, "R4 ramp sel2");
    run_window(3, 50000, 255, 2, 0, 0, -1, "R4 alternating sel3");
    // R3: uneven sum 1+2+2+2=7 -> avg 1 with res 16 gives drop of 1
    run_window(0, 1000, 16, 3, 0, 0, -1, "R3 floor average");
    // R5: zero resistance with full-scale current
    run_window(1, 12345, 0, 0, 4095, 0, -1, "R5 zero resistance");
    // R6: droop exactly equal to setpoint, and far above it
    run_window(0, 16, 16, 0, 16, 0, -1, "R6 equal clamp");
    run_window(2, 100, 255, 0, 4095, 0, -1, "R6 saturate");
    // R10: gaps with garbage between samples
    run_window(1, 40000, 200, 1, 500, 2, -1, "R10 gapped ramp");
    // R9: code changed mid-window to slower and to faster
    run_window(0, 30000, 50, 1, 300, 0, 3, "R9 mid change up");
    run_window(3, 30000, 50, 0, 600, 1, 0, "R9 mid change down");
    // R8: big window followed by a small one must not carry over
    run_window(1, 60000, 255, 0, 4095, 0, -1, "R8 heavy window");
    run_window(0, 60000, 255, 0, 1, 0, -1, "R8 light window after heavy");

    repeat (5) @(negedge clk);
    // R7: reference held after traffic stops
    check(exp_q.size() == 0, "R7 scoreboard drained", exp_q.size(), 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule